// File: doc/BRIEF.md
# Byte-Driven I2C Master with Register Interface

This block is an I2C bus master that software runs one byte at a time through five byte-wide registers. A small register port carries writes and reads. A bit engine produces the SCL and SDA waveforms as open-drain enables: a 1 pulls the line low and a 0 releases it. The first data-register write after a transfer begins becomes the address byte, preceded by a START. Each later write shifts out one data byte. In receive direction, each strobed read of the data register starts the next incoming byte.

After each byte, the block records the acknowledge bit it received. When both enables in the control register allow it, the block also raises a level interrupt. Between bytes it holds SCL low until software acts. Software ends a transfer in one of three ways:
- clearing master select, which issues a STOP;
- setting repeated start, so that the next write begins with a new START;
- clearing the enable bit, which performs a soft reset.

Top module: `i2c_byte_master`

## Requirements
- R1: Registers decode at byte offsets 0x00 (own address), 0x04 (divider), 0x08 (control), 0x0C (status) and 0x10 (data). Any other offset, for example 0x06 or 0x14, reads 0x00. After reset, status reads 0x81 and every other register reads 0x00.
- R2: Own address keeps bits [7:1]; writing 0xFF reads back 0xFE. The divider keeps bits [5:0]; writing 0xFF reads back 0x3F. Control bits [1:0] always read 0.
- R3: A data write while control bit 7 (enable) is 0 is ignored. SCL is never driven and status does not change.
- R4: With enable and control bit 5 (master) set, the first data write sends a START and then the byte: bits [7:1] are the slave address and bit 0 is read (1) or write (0). On ACK, status bit 0 (NACK seen) clears, the address is marked sent and the interrupt is raised.
- R5: If the address byte is NACKed, status bit 0 is set, no interrupt is raised and no STOP is sent. The next data write is again an address byte with its own START.
- R6: A data byte that is ACKed clears status bit 0 and raises the interrupt. A NACKed data byte sets status bit 0, sends a STOP and forgets the address.
- R7: When master is set, control bit 4 (transmit) is clear and an address has been sent, a strobed data read returns the previous received byte and starts the next one. Completion stores the new byte and raises the interrupt. During that byte's acknowledge slot, the master sends ACK if control bit 3 is 0 and NACK if it is 1.
- R8: With master set, a data read returns 0xFF if no address has been sent or if the transmit bit is set.
- R9: Status bit 1 (interrupt pending) can only be set while control bits 7 and 6 (interrupt enable) are both 1.
- R10: Writing 0 to status bit 1 clears it, and writing 1 leaves it unchanged. The `irq` output always equals status bit 1.
- R11: Writing master = 1 sets status bit 5 (bus busy). Writing master = 0 clears it, forgets the address and, if the bus is held between bytes, sends a STOP.
- R12: Writing control bit 2 (repeated start) while an address is held forgets the address and clears bit 2. The next write then starts with a START and no STOP precedes it.
- R13: Writing control with bit 7 = 0 while enabled returns all registers and the bit engine to reset values, except that the own address keeps its value.
- R14: One SCL period lasts 4*(divider+1) clock cycles. While SCL is high, SDA changes only for START or STOP. Status bit 7 (transfer complete) is 0 while a byte shifts and 1 once the byte finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data register only) |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt, equal to status bit 1 |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
Register reads are combinational, so a register value is checked in the same cycle its offset is presented. A write takes effect at the next rising edge, so its result is checked at the falling edge after the write strobe. Byte results appear only after 36 quarter periods: nine bits of four quarters, each quarter lasting divider+1 cycles. The bench therefore polls the transfer-complete bit at falling edges and allows a fixed margin for a STOP before it checks flags, bus counts or interrupt level. The SCL period is measured between consecutive rising edges of the line and compared with 4*(divider+1) cycles of 20 ns each.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [4:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam logic [4:0] A_OWN = 5'h00;
  localparam logic [4:0] A_DIV = 5'h04;
  localparam logic [4:0] A_CTL = 5'h08;
  localparam logic [4:0] A_STS = 5'h0C;
  localparam logic [4:0] A_DAT = 5'h10;

  typedef enum logic [2:0] {E_IDLE, E_START, E_BITS, E_ACK, E_STOP, E_HOLD} eng_t;

  logic [6:0]       own_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [5:0]       ctl_q;
  logic             icf_q, busy_q, iif_q, rxak_q, addr_ok_q;
  logic [7:0]       rx_q, sh_q;
  eng_t             st_q;
  logic [1:0]       q_q;
  logic [2:0]       bit_q;
  logic             rxm_q, isaddr_q, ackin_q;

  wire en   = ctl_q[5];
  wire ien  = ctl_q[4];
  wire msta = ctl_q[3];
  wire mtx  = ctl_q[2];
  wire txak = ctl_q[1];
  wire rsta = ctl_q[0];

  wire wr_own   = reg_wr && reg_addr == A_OWN;
  wire wr_div   = reg_wr && reg_addr == A_DIV;
  wire wr_ctl   = reg_wr && reg_addr == A_CTL;
  wire wr_sts   = reg_wr && reg_addr == A_STS;
  wire wr_dat   = reg_wr && reg_addr == A_DAT;
  wire soft_rst = wr_ctl && en && !reg_wdata[7];
  wire parked   = st_q == E_IDLE || st_q == E_HOLD;
  wire go_tx    = wr_dat && en && msta && parked;
  wire go_rx    = reg_rd && reg_addr == A_DAT && en && msta && !mtx && addr_ok_q && st_q == E_HOLD;
  wire bad_rd   = msta && (!addr_ok_q || mtx);
  wire tick     = cnt_q == div_q;
  wire last_q   = q_q == 2'd3;
  wire raise    = en && ien;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) own_q <= '0;
    else if (wr_own) own_q <= reg_wdata[7:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; ctl_q <= '0; icf_q <= 1'b1; busy_q <= 1'b0; iif_q <= 1'b0;
      rxak_q <= 1'b1; addr_ok_q <= 1'b0; rx_q <= '0; sh_q <= '0; st_q <= E_IDLE;
      q_q <= '0; cnt_q <= '0; bit_q <= '0; rxm_q <= 1'b0; isaddr_q <= 1'b0; ackin_q <= 1'b0;
    end else if (soft_rst) begin
      div_q <= '0; ctl_q <= '0; icf_q <= 1'b1; busy_q <= 1'b0; iif_q <= 1'b0;
      rxak_q <= 1'b1; addr_ok_q <= 1'b0; rx_q <= '0; sh_q <= '0; st_q <= E_IDLE;
      q_q <= '0; cnt_q <= '0; bit_q <= '0; rxm_q <= 1'b0; isaddr_q <= 1'b0; ackin_q <= 1'b0;
    end else begin
      if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
      if (wr_ctl) begin
        ctl_q  <= reg_wdata[7:2];
        busy_q <= reg_wdata[5];
        if (!reg_wdata[5]) begin
          addr_ok_q <= 1'b0;
          if (st_q == E_HOLD) begin
            st_q <= E_STOP; q_q <= '0; cnt_q <= '0;
          end
        end
        if (reg_wdata[2] && addr_ok_q) begin
          addr_ok_q <= 1'b0;
          ctl_q[0]  <= 1'b0;
        end
      end
      if (wr_sts && !reg_wdata[1]) iif_q <= 1'b0;
      if (go_tx) begin
        sh_q <= reg_wdata; rxm_q <= 1'b0; isaddr_q <= !addr_ok_q; icf_q <= 1'b0;
        cnt_q <= '0; q_q <= '0; bit_q <= 3'd7;
        st_q <= addr_ok_q ? E_BITS : E_START;
      end
      if (go_rx) begin
        sh_q <= '0; rxm_q <= 1'b1; isaddr_q <= 1'b0; icf_q <= 1'b0;
        cnt_q <= '0; q_q <= '0; bit_q <= 3'd7; st_q <= E_BITS;
      end
      if (!parked) begin
        cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (tick) begin
          q_q <= q_q + 2'd1;
          case (st_q)
            E_START: if (last_q) st_q <= E_BITS;
            E_BITS: begin
              if (q_q == 2'd1 && rxm_q) sh_q[bit_q] <= sda_in;
              if (last_q) begin
                if (bit_q == 3'd0) st_q <= E_ACK;
                else bit_q <= bit_q - 3'd1;
              end
            end
            E_ACK: begin
              if (q_q == 2'd1) ackin_q <= sda_in;
              if (last_q) begin
                icf_q <= 1'b1;
                st_q  <= E_HOLD;
                if (rxm_q) begin
                  rx_q <= sh_q;
                  if (raise) iif_q <= 1'b1;
                end else if (isaddr_q) begin
                  rxak_q <= ackin_q;
                  if (!ackin_q) begin
                    addr_ok_q <= 1'b1;
                    if (raise) iif_q <= 1'b1;
                  end
                end else begin
                  rxak_q <= ackin_q;
                  if (ackin_q) begin
                    addr_ok_q <= 1'b0; st_q <= E_STOP;
                  end else if (raise) iif_q <= 1'b1;
                end
              end
            end
            E_STOP: if (q_q == 2'd2) st_q <= E_IDLE;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st_q)
      E_START: begin scl_oe = q_q == 2'd0 || last_q; sda_oe = q_q[1]; end
      E_BITS:  begin scl_oe = q_q == 2'd0 || last_q; sda_oe = !rxm_q && !sh_q[bit_q]; end
      E_ACK:   begin scl_oe = q_q == 2'd0 || last_q; sda_oe = rxm_q && !txak; end
      E_STOP:  begin scl_oe = q_q == 2'd0; sda_oe = !q_q[1]; end
      E_HOLD:  scl_oe = 1'b1;
      default: ;
    endcase
  end

  always_comb
    case (reg_addr)
      A_OWN:   reg_rdata = {own_q, 1'b0};
      A_DIV:   reg_rdata = 8'(div_q);
      A_CTL:   reg_rdata = {ctl_q, 2'b00};
      A_STS:   reg_rdata = {icf_q, 1'b0, busy_q, 3'b000, iif_q, rxak_q};
      A_DAT:   reg_rdata = bad_rd ? 8'hFF : rx_q;
      default: reg_rdata = 8'h00;
    endcase

  assign irq = iif_q;

  // R14
  sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && (st_q == E_BITS || st_q == E_ACK) && $past(st_q) == st_q)
    |-> $stable(sda_oe));
  // R14
  icf_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_BITS) |-> !icf_q);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (en && ien));
  // R3
  off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && !en && parked) |=> ($stable(st_q) && $stable(sh_q)));
  // R11
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !soft_rst && reg_wdata[5]) |=> busy_q);
  // R12
  rsta_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !soft_rst && reg_wdata[2] && addr_ok_q && parked) |=> (!rsta && !addr_ok_q));
  // R13
  keep_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> $stable(own_q));
endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_low = 0;
  wire scl_bus = ~scl_oe;
  wire sda_bus = ~(sda_oe | slv_low);

  always #10 clk = ~clk;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_bus));

  int checks = 0, errors = 0;
  localparam logic [6:0] SLV = 7'h2A;

  // behavioral slave
  int starts = 0, stops = 0, bitn = 0;
  logic active = 0, is_addr = 0, rd_mode = 0, addr_ok = 0, mack = 0;
  logic [7:0] sh = 0, txb = 0, last_addr = 0, last_wr = 0;
  logic mack_hist [2];
  int rd_idx = 0;

  function automatic logic [7:0] rd_byte(int i);
    return (i == 0) ? 8'hA5 : 8'h3C;
  endfunction

  always @(negedge sda_bus) if (scl_bus === 1'b1) begin
    starts++; active = 1; is_addr = 1; bitn = 0; slv_low = 0;
  end
  always @(posedge sda_bus) if (scl_bus === 1'b1) begin
    stops++; active = 0; slv_low = 0;
  end
  always @(posedge scl_bus) if (active) begin
    if (bitn < 8) begin sh = {sh[6:0], sda_bus}; bitn++; end
    else if (bitn == 8) begin mack = !sda_bus; bitn = 9; end
  end
  always @(negedge scl_bus) if (active) begin
    if (bitn == 8) begin
      if (is_addr) begin
        last_addr = sh;
        addr_ok = sh[7:1] == SLV;
        rd_mode = sh[0];
        slv_low = addr_ok;
      end else if (!rd_mode) begin
        last_wr = sh;
        slv_low = sh != 8'hEE;
      end else slv_low = 0;
    end else if (bitn == 9) begin
      bitn = 0;
      if (is_addr) begin
        is_addr = 0;
        if (!addr_ok) begin active = 0; slv_low = 0; end
        else if (rd_mode) begin txb = rd_byte(rd_idx); slv_low = ~txb[7]; end
        else slv_low = 0;
      end else if (rd_mode) begin
        if (rd_idx < 2) mack_hist[rd_idx] = mack;
        rd_idx++;
        if (mack) begin txb = rd_byte(rd_idx); slv_low = ~txb[7]; end
        else begin slv_low = 0; active = 0; end
      end else slv_low = 0;
    end else if (bitn > 0 && rd_mode && !is_addr) slv_low = ~txb[7-bitn];
  end

  // SCL period and drive monitors
  longint t_prev = 0, t_last = 0;
  int scl_drv = 0;
  always @(posedge scl_bus) begin t_prev = t_last; t_last = $time; end
  always @(posedge clk) if (scl_oe) scl_drv++;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic rd_kick(output logic [7:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = 5'h10; #1; v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (n < 3000) begin
      @(negedge clk); reg_addr = 5'h0C; #1;
      if (reg_rdata[7]) break;
      n++;
    end
    if (n >= 3000) chk(8'h00, 8'h80, {tag, " completion timeout"});
    repeat (16) @(negedge clk);
  endtask

  // {write, offset, data, expected read}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 5'h0C, 8'h00, 8'h81},  // R1 status reset
    {1'b0, 5'h00, 8'h00, 8'h00},  // R1
    {1'b0, 5'h08, 8'h00, 8'h00},  // R1
    {1'b0, 5'h10, 8'h00, 8'h00},  // R1
    {1'b0, 5'h14, 8'h00, 8'h00},  // R1 outside window
    {1'b1, 5'h00, 8'hFF, 8'h00},
    {1'b0, 5'h00, 8'h00, 8'hFE},  // R2
    {1'b1, 5'h04, 8'hFF, 8'h00},
    {1'b0, 5'h04, 8'h00, 8'h3F},  // R2
    {1'b1, 5'h08, 8'h43, 8'h00},
    {1'b0, 5'h08, 8'h00, 8'h40},  // R2
    {1'b0, 5'h06, 8'h00, 8'h00},  // R1 undecoded
    {1'b1, 5'h04, 8'h01, 8'h00},
    {1'b0, 5'h04, 8'h00, 8'h01}   // R2
  };

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    starts = 0; stops = 0; active = 0; slv_low = 0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][15:8]);
      else rd_chk(VEC[i][20:16], VEC[i][7:0], $sformatf("R1/R2 vector %0d", i));
    end

    // R11 master set while disabled, R3 ignored write, R8 no address
    wr(5'h08, 8'h20);
    rd_chk(5'h0C, 8'hA1, "R11 busy set");
    scl_drv = 0;
    wr(5'h10, 8'h50);
    repeat (30) @(negedge clk);
    chk(8'(scl_drv), 8'h00, "R3 scl untouched when disabled");
    rd_chk(5'h0C, 8'hA1, "R3 status unchanged");
    rd_chk(5'h10, 8'hFF, "R8 read without address");
    wr(5'h08, 8'h00);
    rd_chk(5'h0C, 8'h81, "R11 busy cleared");

    // R4 address write
    wr(5'h08, 8'hC0);
    wr(5'h08, 8'hF0);
    wr(5'h10, {SLV, 1'b0});
    wait_done("R4");
    chk(8'(starts), 8'd1, "R4 one START");
    chk(last_addr, {SLV, 1'b0}, "R4 address byte on bus");
    rd_chk(5'h0C, 8'hA2, "R4 status after ack");
    chk(8'(irq), 8'd1, "R4 irq raised");

    // R10
    wr(5'h0C, 8'hFF);
    chk(8'(irq), 8'd1, "R10 writing one keeps pending");
    wr(5'h0C, 8'h00);
    chk(8'(irq), 8'd0, "R10 writing zero clears");
    rd_chk(5'h0C, 8'hA0, "R10 status");

    // R14 + R6 ack
    wr(5'h10, 8'h11);
    rd_chk(5'h0C, 8'h20, "R14 complete flag low while shifting");
    wait_done("R6");
    chk(8'(t_last - t_prev), 8'(4 * 2 * 20), "R14 scl period");
    chk(last_wr, 8'h11, "R6 data byte on bus");
    chk(8'(irq), 8'd1, "R6 irq on ack");
    wr(5'h0C, 8'h00);

    // R6 nack
    p0 = stops;
    wr(5'h10, 8'hEE);
    wait_done("R6");
    rd_chk(5'h0C, 8'hA1, "R6 nack flag");
    chk(8'(stops - p0), 8'd1, "R6 STOP after data nack");
    s0 = starts;
    wr(5'h10, {SLV, 1'b0});
    wait_done("R6");
    chk(8'(starts - s0), 8'd1, "R6 next write is address");
    rd_chk(5'h0C, 8'hA2, "R6 address acked again");
    wr(5'h0C, 8'h00);

    // R12 repeated start into read
    wr(5'h08, 8'hF4);
    rd_chk(5'h08, 8'hF0, "R12 restart bit cleared");
    s0 = starts; p0 = stops;
    wr(5'h10, {SLV, 1'b1});
    wait_done("R12");
    chk(8'(starts - s0), 8'd1, "R12 new START");
    chk(8'(stops - p0), 8'd0, "R12 no STOP");
    wr(5'h0C, 8'h00);

    // R7 receive
    wr(5'h08, 8'hE0);
    rd_kick(v);
    chk(v, 8'h00, "R7 kick returns previous byte");
    wait_done("R7");
    chk(8'(irq), 8'd1, "R7 irq on receive");
    rd_chk(5'h10, 8'hA5, "R7 first byte");
    wr(5'h0C, 8'h00);
    wr(5'h08, 8'hE8);
    rd_kick(v);
    chk(v, 8'hA5, "R7 second kick returns first byte");
    wait_done("R7");
    rd_chk(5'h10, 8'h3C, "R7 second byte");
    chk(8'(mack_hist[0]), 8'd1, "R7 ack with bit3 clear");
    chk(8'(mack_hist[1]), 8'd0, "R7 nack with bit3 set");
    wr(5'h0C, 8'h00);

    // R8 transmit direction
    wr(5'h08, 8'hF8);
    rd_chk(5'h10, 8'hFF, "R8 read in transmit direction");

    // R11 stop by clearing master
    p0 = stops;
    wr(5'h08, 8'hC0);
    repeat (20) @(negedge clk);
    chk(8'(stops - p0), 8'd1, "R11 STOP on master clear");
    rd_chk(5'h0C, 8'h80, "R11 busy cleared");
    chk({6'd0, scl_oe, sda_oe}, 8'h00, "R11 lines released");
    rd_chk(5'h10, 8'h3C, "R8 no 0xFF when master clear");

    // R9 interrupt enable off
    wr(5'h08, 8'hB0);
    wr(5'h10, {SLV, 1'b0});
    wait_done("R9");
    chk(8'(irq), 8'd0, "R9 no irq with enable low");
    rd_chk(5'h0C, 8'hA0, "R9 status");
    wr(5'h08, 8'h80);
    repeat (20) @(negedge clk);

    // R5 address nack
    wr(5'h08, 8'hF0);
    p0 = stops;
    wr(5'h10, 8'h20);
    wait_done("R5");
    rd_chk(5'h0C, 8'hA1, "R5 nack flag, no pending");
    chk(8'(irq), 8'd0, "R5 no irq");
    chk(8'(stops - p0), 8'd0, "R5 no STOP");
    s0 = starts;
    wr(5'h10, {SLV, 1'b0});
    wait_done("R5");
    chk(8'(starts - s0), 8'd1, "R5 retry sends START");
    rd_chk(5'h0C, 8'hA2, "R5 retry acked");

    // R13 soft reset
    wr(5'h04, 8'h03);
    wr(5'h08, 8'h00);
    rd_chk(5'h00, 8'hFE, "R13 own address kept");
    rd_chk(5'h04, 8'h00, "R13 divider reset");
    rd_chk(5'h08, 8'h00, "R13 control reset");
    rd_chk(5'h0C, 8'h81, "R13 status reset");
    rd_chk(5'h10, 8'h00, "R13 data reset");
    chk({6'd0, scl_oe, irq}, 8'h00, "R13 scl released, irq low");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule